// File: doc/BRIEF.md
# Multiphase-Clock High-Resolution Digital PWM

This block produces one pulse-width-modulated output. An n-bit duty command sets the high time in steps of one phase interval, which is a fraction 1/2^FW of a counter-clock period. The upper CW bits of the command set the coarse high time. A free-running synchronous counter and an equality compare handle that part. The lower FW bits pick which of 2^FW evenly spaced clock phases times the end of the pulse. The edges come from 2^(FW-1) phase-shifted copies of the counter clock together with the falling edges of those copies.

Start and stop requests are decoded in the counter-clock domain and registered there. A falling-edge stage in the same domain moves them halfway across the period. Each request is then taken into one phase stage. Start and stop requests pass through an identical chain. Each phase stage flips a toggle flag, and the output is the parity of all the flags. This gives the behaviour of a set/clear latch built only from edge-triggered flops. A new duty command takes effect only when the counter wraps, so a pulse that has already started always completes.

Top module: `phase_dpwm`

## Requirements
- R1: While reset is asserted, and after release until a nonzero command has been loaded, `pwm_out` is 0 regardless of `duty_cmd`.
- R2: The output period is exactly 2^CW counter-clock periods, which is 256 clocks at the default width, with one rising edge per period.
- R3: For a nonzero command, the high time equals the command value multiplied by one phase interval (counter period / 2^FW). The command is read as an unsigned number whose upper CW bits are the coarse count.
- R4: The lower FW bits of the command add that many phase intervals to the high time, even when the coarse field is 0. Exactly one phase stage carries a stop request at a time.
- R5: A command of 0 keeps `pwm_out` at 0 for the whole period.
- R6: `duty_cmd` is captured only in the cycle in which the counter holds its all-ones value. A pulse in progress keeps the width of the command it started with.
- R7: The largest command (all ones) gives a high time one phase interval shorter than the period, and the pulse ends before the next one starts.
- R8: The rising edge falls (2^FW/2+1) phase intervals after a counter-clock rising edge, which is 5 of 8 at the default. The falling edge falls (2^FW/2+1+fine) mod 2^FW phase intervals after a counter-clock rising edge, where fine is the value of the lower FW bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter clock; equal to phase 0 |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| phase_clk | input | 2^FW/2 | Phase clocks; bit i lags `clk` by i phase intervals |
| duty_cmd | input | CW+FW | Duty command in phase-interval units |
| pwm_out | output | 1 | Modulated output |

## Verification
A wrong coarse count or a bad command capture shows as a pulse width that is off by whole counter periods. It appears on the first pulse after the wrap that loads the command. A wrong phase choice, or a stop request caught by two phase stages, either moves the falling edge to the wrong position within the counter period or leaves the toggle parity inverted. An inverted parity shows as a stuck or inverted output within one period. The bench therefore times every pulse to the phase interval, and it also checks the position of each edge modulo the counter period.

// File: rtl/phase_dpwm_pkg.sv
`timescale 1ns/1ps
package phase_dpwm_pkg;

  // Phase stage that starts every pulse. The request reaches the falling-edge
  // stage half a period after the counter edge, so the first later phase is
  // one step beyond the midpoint.
  function automatic int unsigned lead_phase(int unsigned fw);
    int unsigned nph;
    nph = 1 << fw;
    return (nph / 2 + 1) % nph;
  endfunction

endpackage

// File: rtl/phase_dpwm_rst_sync.sv
`timescale 1ns/1ps
module phase_dpwm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/phase_dpwm_coarse.sv
`timescale 1ns/1ps
module phase_dpwm_coarse
  import phase_dpwm_pkg::*;
#(
  parameter int unsigned CW = 8,
  parameter int unsigned FW = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [CW+FW-1:0]       duty_cmd,
  output logic                   set_q,
  output logic [(2**FW)-1:0]     clr_vec_q
);

  localparam int unsigned NW   = CW + FW;
  localparam int unsigned NPH  = 2 ** FW;
  localparam logic [FW-1:0] LEAD = FW'(lead_phase(FW));

  logic [CW-1:0]  cnt_q, cnt_d;
  logic [NW-1:0]  duty_q, duty_d;
  logic           wrap;
  logic           active;
  logic           set_d;
  logic           clr_hit;
  logic [FW-1:0]  phase_sel;
  logic [NPH-1:0] clr_vec_d;

  // next-state logic
  always_comb begin
    wrap      = (cnt_q == '1);
    cnt_d     = cnt_q + 1'b1;
    duty_d    = wrap ? duty_cmd : duty_q;
    active    = |duty_q;
    set_d     = active && (cnt_q == '0);
    clr_hit   = active && (cnt_q == duty_q[NW-1:FW]);
    phase_sel = duty_q[FW-1:0] + LEAD;
  end

  for (genvar p = 0; p < NPH; p++) begin : g_sel
    assign clr_vec_d[p] = clr_hit && (phase_sel == FW'(p));
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      duty_q    <= '0;
      set_q     <= 1'b0;
      clr_vec_q <= '0;
    end else begin
      cnt_q     <= cnt_d;
      duty_q    <= duty_d;
      set_q     <= set_d;
      clr_vec_q <= clr_vec_d;
    end
  end

  // R2
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '1) |=> (cnt_q == '0));

  // R6
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '1) |=> $stable(duty_q));

  // R3
  clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_vec_q) |=> !(|clr_vec_q));

  // R5
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_q == '0) |=> (!set_q && (clr_vec_q == '0)));

endmodule

// File: rtl/phase_dpwm_retime.sv
`timescale 1ns/1ps
module phase_dpwm_retime #(
  parameter int unsigned NPH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPH/2-1:0]   phase_clk,
  input  logic [NPH-1:0]     req_vec,
  output logic [NPH-1:0]     tog_q
);

  localparam int unsigned NCLK = NPH / 2;

  // Falling-edge stage: moves requests half a period away from the counter
  // edge so every phase stage samples a settled value.
  logic [NPH-1:0] half_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= '0;
    end else begin
      half_q <= req_vec;
    end
  end

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    logic t_q;
    logic t_d;

    always_comb begin
      t_d = ~t_q;
    end

    if (p < NCLK) begin : g_rise
      always_ff @(posedge phase_clk[p] or negedge rst_n) begin
        if (!rst_n) begin
          t_q <= 1'b0;
        end else if (half_q[p]) begin
          t_q <= t_d;
        end
      end
    end else begin : g_fall
      always_ff @(negedge phase_clk[p-NCLK] or negedge rst_n) begin
        if (!rst_n) begin
          t_q <= 1'b0;
        end else if (half_q[p]) begin
          t_q <= t_d;
        end
      end
    end

    assign tog_q[p] = t_q;
  end

  // R4
  one_phase_chk: assert property (@(negedge clk) disable iff (!rst_n)
    $onehot0(half_q));

endmodule

// File: rtl/phase_dpwm.sv
`timescale 1ns/1ps
module phase_dpwm
  import phase_dpwm_pkg::*;
#(
  parameter int unsigned CW = 8,
  parameter int unsigned FW = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [(2**FW)/2-1:0]   phase_clk,
  input  logic [CW+FW-1:0]       duty_cmd,
  output logic                   pwm_out
);

  localparam int unsigned NPH  = 2 ** FW;
  localparam int unsigned LEAD = lead_phase(FW);

  logic           rst_sync_n;
  logic           set_q;
  logic [NPH-1:0] clr_vec_q;
  logic [NPH-1:0] set_vec;
  logic [NPH-1:0] set_tog;
  logic [NPH-1:0] clr_tog;

  phase_dpwm_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  phase_dpwm_coarse #(.CW(CW), .FW(FW)) u_coarse (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .duty_cmd  (duty_cmd),
    .set_q     (set_q),
    .clr_vec_q (clr_vec_q)
  );

  // Start requests take the same path as a stop with fine value 0.
  always_comb begin
    set_vec       = '0;
    set_vec[LEAD] = set_q;
  end

  phase_dpwm_retime #(.NPH(NPH)) u_set_path (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .phase_clk (phase_clk),
    .req_vec   (set_vec),
    .tog_q     (set_tog)
  );

  phase_dpwm_retime #(.NPH(NPH)) u_clr_path (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .phase_clk (phase_clk),
    .req_vec   (clr_vec_q),
    .tog_q     (clr_tog)
  );

  // Set/clear behaviour: every start flips one flag and every stop flips another.
  assign pwm_out = (^set_tog) ^ (^clr_tog);

endmodule

// File: tb/phase_dpwm_bench.sv
`timescale 1ns/1ps
module phase_dpwm_bench;

  localparam int CLK_PERIOD      = 8;
  localparam int CW              = 8;
  localparam int FW              = 3;
  localparam int NPH             = 1 << FW;
  localparam int NW              = CW + FW;
  localparam int STEP            = CLK_PERIOD / NPH;
  localparam int PER_NS          = CLK_PERIOD * (1 << CW);
  localparam int LEAD            = (NPH / 2 + 1) % NPH;
  localparam int WATCHDOG_CYCLES = 150000;

  logic              clk;
  logic              rst_n;
  logic [NPH/2-1:0]  phase_clk;
  logic [NW-1:0]     duty_cmd;
  logic              pwm_out;

  int      checks  = 0;
  int      fails   = 0;
  int      pending = 0;
  bit      done    = 0;
  bit      have_rise = 0;
  realtime rise_t;
  int      exp_q[$];
  string   tag_q[$];

  phase_dpwm #(.CW(CW), .FW(FW)) u_phase_dpwm (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_clk (phase_clk),
    .duty_cmd  (duty_cmd),
    .pwm_out   (pwm_out)
  );

  // All clocks from one process so that edges that coincide are applied together.
  initial begin : clkgen
    int tick;
    tick = 0;
    forever begin
      clk = ((tick % NPH) < NPH / 2);
      for (int i = 0; i < NPH / 2; i++) begin
        phase_clk[i] = (((tick + NPH - i) % NPH) < NPH / 2);
      end
      #(STEP);
      tick++;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // monitor: time each pulse and compare with the scoreboard
  always @(posedge pwm_out) begin
    rise_t    = $realtime;
    have_rise = 1;
  end

  always @(negedge pwm_out) begin : mon
    int    w;
    int    e;
    string tg;
    if (have_rise && pending > 0) begin
      w  = $rtoi(($realtime - rise_t) / STEP + 0.5);
      e  = exp_q.pop_front();
      tg = tag_q.pop_front();
      check(tg, w, e);
      check("R8 rise position", $rtoi(rise_t + 0.5) % CLK_PERIOD, LEAD * STEP);
      check("R8 fall position", $rtoi($realtime + 0.5) % CLK_PERIOD,
            ((LEAD + e) % NPH) * STEP);
      pending--;
    end
  end

  task automatic push_exp(input int val, input string tag);
    exp_q.push_back(val);
    tag_q.push_back(tag);
    pending++;
  endtask

  // driver: apply a command, let a wrap load it, then expect one pulse
  task automatic run_duty(input int val, input string tag);
    duty_cmd = NW'(val);
    #(PER_NS + 4 * CLK_PERIOD);
    push_exp(val, tag);
    wait (pending == 0);
  endtask

  task automatic count_high(input int span_ns, output int n);
    n = 0;
    #0.5;
    for (int i = 0; i < span_ns; i++) begin
      if (pwm_out) n++;
      #(STEP);
    end
  endtask

  task automatic check_period(input string tag);
    realtime t1;
    @(posedge pwm_out);
    t1 = $realtime;
    @(posedge pwm_out);
    check(tag, $rtoi($realtime - t1 + 0.5), PER_NS);
  endtask

  initial begin : watchdog
    #(WATCHDOG_CYCLES * CLK_PERIOD);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin : main
    int n;
    rst_n    = 1'b0;
    duty_cmd = '0;
    #(3 * CLK_PERIOD + 3);
    count_high(4 * CLK_PERIOD, n);
    check("R1 low in reset", n, 0);
    duty_cmd = NW'(1000);
    count_high(4 * CLK_PERIOD, n);
    check("R1 command ignored in reset", n, 0);
    duty_cmd = '0;
    #2.5;
    rst_n = 1'b1;
    count_high(PER_NS, n);
    check("R1 low after release", n, 0);

    run_duty(1,    "R4 fine only 1");
    run_duty(2,    "R4 fine only 2");
    run_duty(7,    "R4 fine only 7");
    run_duty(8,    "R3 one coarse step");
    run_duty(13,   "R3 coarse plus fine");
    run_duty(805,  "R3 mid command");
    run_duty(1024, "R3 half period");
    run_duty(1365, "R3 third");
    check_period("R2 period");
    run_duty(2047, "R7 largest command");
    check_period("R2 period at largest");

    duty_cmd = '0;
    #(PER_NS + 4 * CLK_PERIOD);
    count_high(PER_NS, n);
    check("R5 zero command", n, 0);

    run_duty(1200, "R6 settle wide");
    @(posedge pwm_out);
    push_exp(1200, "R6 shrink keeps current pulse");
    #2;
    duty_cmd = NW'(300);
    push_exp(300, "R6 narrow after wrap");
    wait (pending == 0);

    @(posedge pwm_out);
    push_exp(300, "R6 grow keeps current pulse");
    #2;
    duty_cmd = NW'(1900);
    push_exp(1900, "R6 wide after wrap");
    wait (pending == 0);

    done = 1;
    summary();
    $finish;
  end

endmodule